// File: doc/BRIEF.md
# Two-Channel Down-Counting Event Timer

This block is a register-mapped timer with two independent channels. Each channel holds a 64-bit interval and a 64-bit live count. The bus reads and writes each of these as two 32-bit words. A per-channel control word selects run or stop, an interval load, one-shot or periodic behaviour, and a clock divider. While a channel runs, its count falls by one on every divided tick. When the count has reached zero, the next tick raises that channel's status bit. A periodic channel then reloads its interval and keeps running. A one-shot channel halts.

Starting and stopping are both deliberately slow. A start spends two ticks arming before the first decrement, so the first event lands interval + 3 ticks after the start write. A stop lets the channel run on for exactly two more ticks. Software therefore programs a delay as the wanted tick count minus three, and waits out the stop before it trusts the count. A channel programmed to the all-ones interval and left running periodic serves as a free time base, read through the inverted low count word.

The block has one clock. Each channel's divider is a tick enable taken from a shared free-running counter. A single interrupt line combines the status bits that are enabled.

Top module: `evt_timer_top`

## Requirements
- R1: After reset every readable word is zero and `irq` is low.
- R2: Word addresses are fixed as follows.
  - Interrupt enable is at 0x00 and status at 0x04.
  - Channel n's words start at 0x10 + 0x20·n: control at +0x00, interval low at +0x04, interval high at +0x08, count low at +0x0C and count high at +0x10.
  - Control bits are: bit 0 run, bit 1 load (always reads 0), bits 6:4 divider select, bit 7 one-shot (1) or periodic (0). Other control bits read 0.
  - The enable register keeps only one bit per channel.
- R3: With divider select s, a channel ticks once every 2^s clock cycles. Its count changes only on its ticks.
- R4: A control write with run and load both set does two things on that edge: it copies the interval into the count, and it starts a two-tick arming phase. Decrements follow, one per tick. In one-shot mode the status bit sets on the tick that finds the count at zero, interval + 3 ticks after the write, and the count then stays at 0.
- R5: In periodic mode the tick that finds zero reloads the interval. After the first event, events repeat every interval + 1 ticks.
- R6: A control write with run cleared lets an active channel take exactly two further ticks. After that the count is frozen. The write edge itself takes no tick.
- R7: A control write with run set and load clear re-arms a stopped channel for two ticks. The channel then resumes from its held count.
- R8: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear land on the same edge, the event wins.
- R9: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R10: A bus read of count low, with `bus_rd` high, copies the count's upper word into a per-channel shadow. Count-high reads return that shadow.
- R11: A channel with the all-ones interval running periodic makes the inverted count-low word rise by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state and ticks |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; matters only for the count-low shadow capture |
| bus_addr | input | ADDR_W (8) | Byte address of the word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 1 | Combined masked event line |

## Verification
A corrupted count, arming counter or stop counter in this block appears at the ports as an event on the wrong edge: `irq` rises early or late by the amount of the error, one tick after the count would have reached zero. The reference model compares `irq` on every cycle, so such a slip is reported on the edge where it happens. Explicit checks also measure the edge distance from a start write to an event, and between successive periodic events. A wrong held count after a stop, or a shadow word out of step with the low read, is visible on the next read. These values are compared against distances and values derived from the requirements.

// File: rtl/etmr_pkg.sv
// Package: shared constants and the channel state type of the event timer.
// Assumes byte addressing with 32-bit words and at most eight divider settings.
package etmr_pkg;

    localparam int SEL_W      = 3;
    localparam int NUM_SEL    = 1 << SEL_W;
    localparam int SYNC_TICKS = 2;

    // Control word bit positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_LOAD   = 1;
    localparam int CTL_SEL_LO = 4;
    localparam int CTL_ONE    = 7;

    // Global and per-channel word addresses
    localparam int A_IEN     = 'h00;
    localparam int A_STAT    = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_STRIDE = 'h20;
    localparam int O_CTRL    = 'h00;
    localparam int O_IVL_LO  = 'h04;
    localparam int O_IVL_HI  = 'h08;
    localparam int O_CNT_LO  = 'h0C;
    localparam int O_CNT_HI  = 'h10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/etmr_prescaler.sv
// Module: shared divider producing one tick enable per divider setting.
// Tick s pulses for one cycle out of every 2^s; tick 0 is always high.
// Assumes all channels share the same free-running phase.
module etmr_prescaler
    import etmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_SEL-1:0] tick_o
);
    localparam int FREE_W = NUM_SEL - 1;

    logic [FREE_W-1:0] free_q;

    // Free-running phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + 1'b1;
    end

    // One tick enable per divider setting
    for (genvar s = 0; s < NUM_SEL; s++) begin : g_tick
        if (s == 0) begin : g_full
            assign tick_o[s] = 1'b1;
        end else begin : g_div
            assign tick_o[s] = &free_q[s-1:0];
        end
    end
endmodule

// File: rtl/etmr_chan.sv
// Module: one down-counting channel with arming and stop synchronisation.
// A control write takes priority over a tick on the same edge.
// Assumes the caller decodes addresses and gives at most one write strobe per cycle.
module etmr_chan
    import etmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SEL-1:0]  tick_vec_i,
    input  logic                wr_ctrl_i,
    input  logic                wr_ivl_lo_i,
    input  logic                wr_ivl_hi_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   ctrl_o,
    output logic [2*DATA_W-1:0] ivl_o,
    output logic [2*DATA_W-1:0] cnt_o,
    output logic                fire_o,
    output logic                tick_o
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

    logic             run_q, one_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] ivl_q, cnt_q;
    ch_state_e        state_q;
    logic [SYNC_W-1:0] arm_left_q, stop_left_q;
    logic             w_run, w_load, tick_ok;

    assign w_run   = wdata_i[CTL_RUN];
    assign w_load  = wdata_i[CTL_LOAD];
    assign tick_o  = tick_vec_i[sel_q];
    assign tick_ok = tick_o && !wr_ctrl_i;

    // Stored control fields (the load bit is an action, not stored)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            one_q <= 1'b0;
            sel_q <= '0;
        end else if (wr_ctrl_i) begin
            run_q <= w_run;
            one_q <= wdata_i[CTL_ONE];
            sel_q <= wdata_i[CTL_SEL_LO +: SEL_W];
        end
    end

    // Interval register, written one word at a time
    always_ff @(posedge clk) begin
        if (!rst_n) ivl_q <= '0;
        else if (wr_ivl_lo_i) ivl_q[DATA_W-1:0] <= wdata_i;
        else if (wr_ivl_hi_i) ivl_q[CNT_W-1:DATA_W] <= wdata_i;
    end

    // Channel sequencing: arming, counting, expiry and delayed stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            arm_left_q  <= '0;
            stop_left_q <= '0;
        end else if (wr_ctrl_i) begin
            if (w_run) begin
                stop_left_q <= '0;
                if (w_load) begin
                    cnt_q      <= ivl_q;
                    state_q    <= ST_ARM;
                    arm_left_q <= SYNC_W'(SYNC_TICKS);
                end else if (state_q == ST_IDLE) begin
                    state_q    <= ST_ARM;
                    arm_left_q <= SYNC_W'(SYNC_TICKS);
                end
            end else if (state_q != ST_IDLE && stop_left_q == '0) begin
                stop_left_q <= SYNC_W'(SYNC_TICKS);
            end
        end else if (tick_ok) begin
            case (state_q)
                ST_ARM: begin
                    if (arm_left_q == SYNC_W'(1)) state_q <= ST_RUN;
                    arm_left_q <= arm_left_q - 1'b1;
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        if (one_q) state_q <= ST_IDLE;
                        else       cnt_q   <= ivl_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
            if (stop_left_q != '0) begin
                stop_left_q <= stop_left_q - 1'b1;
                if (stop_left_q == SYNC_W'(1)) state_q <= ST_IDLE;
            end
        end
    end

    // Event pulse on the tick that finds a running count at zero
    assign fire_o = tick_ok && (state_q == ST_RUN) && (cnt_q == '0);

    // Readback views
    always_comb begin
        ctrl_o = '0;
        ctrl_o[CTL_RUN] = run_q;
        ctrl_o[CTL_ONE] = one_q;
        ctrl_o[CTL_SEL_LO +: SEL_W] = sel_q;
    end
    assign ivl_o = ivl_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_timer_top.sv
// Module: two-channel event timer with word-addressed registers and one interrupt.
// Decodes the register map, holds enable, status and count-high shadows, and
// merges channel events. Assumes one bus access per cycle; reads are combinational.
module evt_timer_top
    import etmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(A_STAT);

    logic [NUM_SEL-1:0] tick_vec;
    logic [NUM_CH-1:0]  ien_q, status_q, fire_vec, chan_tick;
    logic [DATA_W-1:0]  ch_rd [NUM_CH];
    logic               wr_stat;

    etmr_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * g;
        localparam logic [ADDR_W-1:0] AC  = ADDR_W'(BASE + O_CTRL);
        localparam logic [ADDR_W-1:0] AIL = ADDR_W'(BASE + O_IVL_LO);
        localparam logic [ADDR_W-1:0] AIH = ADDR_W'(BASE + O_IVL_HI);
        localparam logic [ADDR_W-1:0] ACL = ADDR_W'(BASE + O_CNT_LO);
        localparam logic [ADDR_W-1:0] ACH = ADDR_W'(BASE + O_CNT_HI);

        logic [DATA_W-1:0] ctrl_w;
        logic [CNT_W-1:0]  ivl_w, cnt_w;
        logic [DATA_W-1:0] shadow_q;

        etmr_chan #(.DATA_W(DATA_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_vec_i  (tick_vec),
            .wr_ctrl_i   (bus_wr && bus_addr == AC),
            .wr_ivl_lo_i (bus_wr && bus_addr == AIL),
            .wr_ivl_hi_i (bus_wr && bus_addr == AIH),
            .wdata_i     (bus_wdata),
            .ctrl_o      (ctrl_w),
            .ivl_o       (ivl_w),
            .cnt_o       (cnt_w),
            .fire_o      (fire_vec[g]),
            .tick_o      (chan_tick[g])
        );

        // Capture the upper count word when the lower word is read
        always_ff @(posedge clk) begin
            if (!rst_n) shadow_q <= '0;
            else if (bus_rd && bus_addr == ACL) shadow_q <= cnt_w[CNT_W-1:DATA_W];
        end

        // Per-channel read selection
        always_comb begin
            unique case (bus_addr)
                AC:      ch_rd[g] = ctrl_w;
                AIL:     ch_rd[g] = ivl_w[DATA_W-1:0];
                AIH:     ch_rd[g] = ivl_w[CNT_W-1:DATA_W];
                ACL:     ch_rd[g] = cnt_w[DATA_W-1:0];
                ACH:     ch_rd[g] = shadow_q;
                default: ch_rd[g] = '0;
            endcase
        end
    end

    assign wr_stat = bus_wr && bus_addr == ADDR_STAT;

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n) ien_q <= '0;
        else if (bus_wr && bus_addr == ADDR_IEN) ien_q <= bus_wdata[NUM_CH-1:0];
    end

    // Status bits: events set, ones written clear, an event wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else status_q <= fire_vec | (status_q & ~(wr_stat ? bus_wdata[NUM_CH-1:0] : '0));
    end

    // Read data merge
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_IEN)  bus_rdata[NUM_CH-1:0] = ien_q;
        if (bus_addr == ADDR_STAT) bus_rdata[NUM_CH-1:0] = status_q;
        for (int c = 0; c < NUM_CH; c++) bus_rdata = bus_rdata | ch_rd[c];
    end

    assign irq = |(status_q & ien_q);
endmodule

// File: rtl/evt_timer_chk.sv
// Module: assertion checker for the event timer, attached by bind.
// Observes status, enable, channel events and ticks against the bus.
module evt_timer_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] clr_bits,
    input logic [NUM_CH-1:0] status_q,
    input logic [NUM_CH-1:0] ien_q,
    input logic [NUM_CH-1:0] fire_vec,
    input logic [NUM_CH-1:0] chan_tick
);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(4);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R8: a status bit only rises after its channel's event
        assert_rise_from_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[i]) |-> $past(fire_vec[i]));
        // R8: a set bit stays set unless a one is written to it
        assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !(bus_wr && bus_addr == ADDR_STAT && clr_bits[i])) |=> status_q[i]);
        // R8: a written one clears the bit when no event coincides
        assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_STAT && clr_bits[i] && !fire_vec[i]) |=> !status_q[i]);
        // R3: events happen only on the channel's own tick
        assert_event_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fire_vec[i] |-> chan_tick[i]);
    end

    // R9: nothing enabled, no interrupt
    assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
    // R9: an interrupt needs a pending status bit
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0));
endmodule

bind evt_timer_top evt_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .clr_bits  (bus_wdata[NUM_CH-1:0]),
    .status_q  (status_q),
    .ien_q     (ien_q),
    .fire_vec  (fire_vec),
    .chan_tick (chan_tick)
);

// File: tb/evt_timer_top_tb_top.sv
// Bench: behavioural reference model compared every clock, plus timed scenario checks.
module evt_timer_top_tb_top;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #4 clk = ~clk;   // 125 MHz

    evt_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    longint ecount = 0;
    bit done = 1'b0;

    always @(posedge clk) ecount <= ecount + 1;

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit              m_one[NCH];
    bit              m_run[NCH];
    int              m_sel[NCH];
    longint unsigned m_ivl[NCH], m_cnt[NCH], m_sh[NCH];
    int              m_st[NCH], m_arm[NCH], m_stop[NCH];
    int              m_ien, m_stat, m_fc;

    always @(posedge clk) begin
        int fc_now, fire, a, b, p;
        bit tk;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_one[c] = 0; m_run[c] = 0; m_sel[c] = 0; m_ivl[c] = 0; m_cnt[c] = 0;
                m_sh[c] = 0; m_st[c] = 0; m_arm[c] = 0; m_stop[c] = 0;
            end
            m_ien = 0; m_stat = 0; m_fc = 0;
        end else begin
            fc_now = m_fc;
            m_fc = (m_fc + 1) % 128;
            fire = 0;
            a = int'(bus_addr);
            for (int c = 0; c < NCH; c++) begin
                b = 16 + 32 * c;
                p = 1 << m_sel[c];
                tk = ((fc_now % p) == p - 1);
                if (bus_rd && a == b + 12) m_sh[c] = m_cnt[c] >> 32;
                if (bus_wr && a == b) begin
                    m_run[c] = bus_wdata[0];
                    m_one[c] = bus_wdata[7];
                    m_sel[c] = int'(bus_wdata[6:4]);
                    if (bus_wdata[0]) begin
                        m_stop[c] = 0;
                        if (bus_wdata[1]) begin m_cnt[c] = m_ivl[c]; m_st[c] = 1; m_arm[c] = 2; end
                        else if (m_st[c] == 0) begin m_st[c] = 1; m_arm[c] = 2; end
                    end else if (m_st[c] != 0 && m_stop[c] == 0) m_stop[c] = 2;
                end else if (tk) begin
                    if (m_st[c] == 1) begin
                        m_arm[c]--;
                        if (m_arm[c] == 0) m_st[c] = 2;
                    end else if (m_st[c] == 2) begin
                        if (m_cnt[c] == 0) begin
                            fire |= (1 << c);
                            if (m_one[c]) m_st[c] = 0; else m_cnt[c] = m_ivl[c];
                        end else m_cnt[c]--;
                    end
                    if (m_stop[c] != 0) begin
                        m_stop[c]--;
                        if (m_stop[c] == 0) m_st[c] = 0;
                    end
                end
                if (bus_wr && a == b + 4) m_ivl[c] = {m_ivl[c][63:32], bus_wdata};
                if (bus_wr && a == b + 8) m_ivl[c] = {bus_wdata, m_ivl[c][31:0]};
            end
            if (bus_wr && a == 4) m_stat = m_stat & ~int'(bus_wdata[1:0]);
            m_stat = m_stat | fire;
            if (bus_wr && a == 0) m_ien = int'(bus_wdata[1:0]);
        end
    end

    function automatic longint unsigned model_read(input int a);
        for (int c = 0; c < NCH; c++) begin
            int b;
            b = 16 + 32 * c;
            if (a == b)      return (longint'(m_one[c]) << 7) | (longint'(m_sel[c]) << 4) | longint'(m_run[c]);
            if (a == b + 4)  return m_ivl[c] & 64'hFFFF_FFFF;
            if (a == b + 8)  return m_ivl[c] >> 32;
            if (a == b + 12) return m_cnt[c] & 64'hFFFF_FFFF;
            if (a == b + 16) return m_sh[c];
        end
        if (a == 0) return longint'(m_ien);
        if (a == 4) return longint'(m_stat);
        return 0;
    endfunction

    // R9: interrupt line against the model on every cycle
    always @(negedge clk) if (rst_n && !done) chk("R9 irq vs model", irq, ((m_stat & m_ien) != 0));

    // ---------------- bus tasks (entered at a falling edge) ----------------
    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input string tag, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = 8'(a);
        #1 d = bus_rdata;
        chk(tag, d, model_read(a));
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        bus_addr = 8'(a);
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    function automatic int actl(input int c); return 16 + 32 * c; endfunction
    function automatic int aivl(input int c); return 20 + 32 * c; endfunction
    function automatic int aivh(input int c); return 24 + 32 * c; endfunction
    function automatic int acnl(input int c); return 28 + 32 * c; endfunction
    function automatic int acnh(input int c); return 32 + 32 * c; endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        longint ew, t1, e1;
        int changes;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything zero after reset
        for (int a = 0; a <= 'h40; a += 4) begin
            peek(a, v);
            chk("R1 reset word", v, 0);
        end
        chk("R1 irq after reset", irq, 0);

        // R2: register map and field layout
        wr(aivl(0), 32'h1234_5678); wr(aivh(0), 32'h9ABC_DEF0);
        wr(aivl(1), 32'h0BAD_F00D); wr(aivh(1), 32'h0000_00C3);
        peek(aivl(0), v); chk("R2 ch0 interval low", v, 32'h1234_5678);
        peek(aivh(0), v); chk("R2 ch0 interval high", v, 32'h9ABC_DEF0);
        peek(aivl(1), v); chk("R2 ch1 interval low", v, 32'h0BAD_F00D);
        peek(aivh(1), v); chk("R2 ch1 interval high", v, 32'h0000_00C3);
        wr(actl(0), 32'hFFFF_FFB2);           // run clear, load set: no load
        peek(actl(0), v); chk("R2 control readback", v, 32'hB0);
        peek(acnl(0), v); chk("R2 no load without run", v, 0);
        wr(0, 32'hFFFF_FFFF);
        peek(0, v); chk("R2 enable width", v, 3);

        // R4: one-shot expiry at interval + 3 ticks
        wr(aivl(0), 5); wr(aivh(0), 0); wr(0, 1);
        wr(actl(0), 32'h83); ew = ecount;
        wait_irq();
        chk("R4 one-shot delay", ecount - ew, 8);
        peek(acnl(0), v); chk("R4 count at zero", v, 0);
        idle(6);
        peek(acnl(0), v); chk("R4 one-shot stays stopped", v, 0);
        wr(4, 1);
        chk("R8 clear drops irq", irq, 0);
        peek(4, v); chk("R8 status cleared", v, 0);

        // R8: event beats a clear on the same edge
        wr(actl(0), 32'h83); ew = ecount;
        idle(7);
        wr(4, 1);
        chk("R8 event edge", ecount - ew, 8);
        peek(4, v); chk("R8 event wins tie", v, 1);
        wr(4, 1);

        // R5: periodic repeat every interval + 1 ticks
        wr(aivl(1), 3); wr(aivh(1), 0); wr(0, 2);
        wr(actl(1), 32'h03); ew = ecount;
        wait_irq();
        chk("R5 first periodic event", ecount - ew, 6);
        t1 = ecount;
        wr(4, 0);
        peek(4, v); chk("R8 zero write keeps status", v, 2);
        wr(4, 2);
        wait_irq();
        chk("R5 period", ecount - t1, 4);
        t1 = ecount;
        wr(4, 2);
        wait_irq();
        chk("R5 period again", ecount - t1, 4);

        // R9: masking
        wr(0, 0);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R9 masked irq low", irq, 0);
        end
        peek(4, v); chk("R9 status pending while masked", v, 2);
        wr(0, 2);
        chk("R9 unmask raises irq", irq, 1);

        // R6: stop takes exactly two more ticks
        wr(aivl(1), 1000);
        wr(actl(1), 32'h03);
        wr(4, 2);
        idle(10);
        peek(acnl(1), v);
        wr(actl(1), 32'h00);
        idle(6);
        peek(acnl(1), v2); chk("R6 count after stop", v2, v - 2);
        idle(5);
        peek(acnl(1), v2); chk("R6 count frozen", v2, v - 2);

        // R7: resume without load after two arming ticks
        wr(actl(1), 32'h01);
        peek(acnl(1), v2); chk("R7 held at write", v2, v - 2);
        idle(2);
        peek(acnl(1), v2); chk("R7 held while arming", v2, v - 2);
        idle(1);
        peek(acnl(1), v2); chk("R7 resumes", v2, v - 3);
        wr(actl(1), 32'h00);
        idle(4);
        wr(4, 3);

        // R3: divider select 2 gives a tick every 4 cycles
        wr(0, 3);
        wr(aivl(0), 2); wr(aivh(0), 0);
        wr(actl(0), 32'hA3); ew = ecount;
        wait_irq();
        chk("R3 divided delay in range", ((ecount - ew) >= 17 && (ecount - ew) <= 20), 1);
        wr(4, 1);
        wr(aivl(0), 100);
        wr(actl(0), 32'h23);
        idle(12);
        changes = 0;
        peek(acnl(0), v);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            peek(acnl(0), v2);
            if (v2 != v) changes++;
            v = v2;
        end
        chk("R3 count changes per 16 cycles", changes, 4);
        wr(actl(0), 32'h20);
        idle(12);

        // R10: high word shadow follows the low read
        wr(aivl(1), 3); wr(aivh(1), 1);
        wr(actl(1), 32'h03);
        idle(3);
        rd(acnl(1), "R10 low read", v);
        chk("R10 low value", v, 2);
        idle(4);
        rd(acnh(1), "R10 shadow read", v);
        chk("R10 shadow holds old high", v, 1);
        rd(acnl(1), "R10 second low read", v);
        rd(acnh(1), "R10 shadow updated", v);
        chk("R10 new high", v, 0);
        wr(actl(1), 32'h00);
        idle(4);

        // R11: inverted count as a rising time base
        wr(aivl(0), 32'hFFFF_FFFF); wr(aivh(0), 32'hFFFF_FFFF);
        wr(actl(0), 32'h03);
        idle(5);
        peek(acnl(0), v); e1 = ecount;
        idle(37);
        peek(acnl(0), v2);
        chk("R11 time base step", 32'(~v2 - ~v), 32'(ecount - e1));
        chk("R11 time base rises", (~v2 > ~v), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule